// File: doc/BRIEF.md
# I2C Word-Register Slave with Auto-Increment

This block is an I2C target that gives a bus master access to a register file with 16-bit addresses and 16-bit words. It samples the serial clock and data lines with the system clock and finds START, repeated START and STOP. It accepts transactions for one fixed 7-bit device address. After the address byte of a write, the next two bytes load a register pointer. Each further pair of bytes forms one word, which the block writes to the register file. A read returns words from the pointer onward. In every case the high byte goes first, and the pointer steps by one after each complete word.

A master reads a chosen register in two steps. It first sets the pointer in a write phase. It then issues a repeated START with the read bit set. A read that opens directly with the device address and the read bit picks up where the previous access left off. The pointer survives between transactions for this reason. The data line is modelled as an input plus an active-high pull-low enable. The register file is reached through a synchronous port: a one-cycle write strobe, and a one-cycle read strobe whose data returns on the next cycle.

Top module: `i2c_word_regslave`

## Requirements
- R1: After reset, the pull-low enable, the write strobe and the read strobe are all low, and the register pointer is zero.
- R2: The first byte after START or repeated START carries the 7-bit device address, most significant bit first, followed by the direction bit (0 = write, 1 = read). When the address matches the parameter, the block acknowledges by pulling the data line low during the ninth clock.
- R3: When the device address does not match, the block does not acknowledge. It then ignores every further clock and data bit, neither acknowledging nor writing, until the next START.
- R4: In a write, the two bytes after the device address set the register pointer, high byte first. The block acknowledges each of them.
- R5: In a write, each following pair of bytes (high, then low) forms one word, and the block acknowledges every byte. Once the low byte is in, a single-cycle write strobe is issued, with the register address equal to the pointer and the write data equal to the word.
- R6: The pointer advances by one after each complete word, whether written or read. It wraps from 0xFFFF to 0x0000.
- R7: A STOP that arrives after only the high byte of a word discards that byte. No write strobe is issued and the register keeps its value.
- R8: In a read, the block sends the word at the pointer, high byte first and most significant bit first. It changes the pull-low enable only while the clock line is low.
- R9: When the master acknowledges the low byte, the block goes on to send the word at the next address.
- R10: When the master does not acknowledge a byte, the block releases the data line and stays off it until the next START.
- R11: A read that starts directly with the device address and the read bit returns data from the address that follows the last word transferred. For example, after words n and n+1 it returns word n+2.
- R12: Register reads use a single-cycle read strobe, with the address held at the pointer. The data is taken from the read-data input on the cycle after the strobe. Read and write strobes never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High to pull the data line low |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_rd_en | output | 1 | Single-cycle register read strobe |
| reg_addr | output | AW | Register address (current pointer) |
| reg_wdata | output | DW | Word to write |
| reg_rdata | input | DW | Word returned one cycle after a read strobe |

## Verification
Two functions meet on the same system-clock edge. The falling clock edge that completes a low data byte commits the word to the register file, and on that same edge the slave starts pulling the line low for its acknowledge. In a read, the falling edge that ends a word's last bit advances the pointer and launches the prefetch of the next word, at the moment the master is about to answer with ACK or NACK. Burst writes across 0x00FF and 0xFFFF provoke the first case. The bench judges it by matching every write strobe against a queue of expected address and data pairs, and by checking that the master saw each acknowledge. Burst reads ended by NACK, followed by reads that start directly with the device address, provoke the second. The returned words must match the reference array at n+2 and beyond, and the data line must be released after the NACK.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_TXACK
   } phase_t;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cw_bus_cond.sv
module i2cw_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  =  scl & ~scl_q;
   assign scl_fall  = ~scl &  scl_q;
   assign start_evt =  scl &  scl_q & ~sda &  sda_q;
   assign stop_evt  =  scl &  scl_q &  sda & ~sda_q;
endmodule

// File: rtl/i2cw_proto.sv
module i2cw_proto
   import i2cw_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h2A,
   parameter int         AW       = 16,
   parameter int         DW       = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_in,
   input  logic          start_evt,
   input  logic          stop_evt,
   output logic          sda_oe,
   output logic          reg_wr_en,
   output logic          reg_rd_en,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   input  logic [DW-1:0] reg_rdata,
   output logic          idle_o
);
   localparam int ABYTES = AW / 8;
   localparam int DBYTES = DW / 8;
   localparam int ACW    = $clog2(ABYTES + 1);
   localparam int DCW    = $clog2(DBYTES + 1);

   phase_t          phase;
   logic [3:0]      bit_cnt;
   logic [7:0]      shreg;
   logic            reading;
   logic            mack;
   logic            oe;
   logic [ACW-1:0]  a_cnt;
   logic [DCW-1:0]  w_cnt;
   logic [DCW-1:0]  tx_cnt;
   logic [AW-1:0]   ptr;
   logic [AW-1:0]   pacc;
   logic [DW-1:0]   wbuf;
   logic [DW-1:0]   wdata_q;
   logic [DW-1:0]   tx_sh;
   logic            wr_q, rd_q, cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         reading <= 1'b0;
         mack    <= 1'b0;
         oe      <= 1'b0;
         a_cnt   <= '0;
         w_cnt   <= '0;
         tx_cnt  <= '0;
         ptr     <= '0;
         pacc    <= '0;
         wbuf    <= '0;
         wdata_q <= '0;
         tx_sh   <= '0;
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         cap_q   <= 1'b0;
      end else begin
         wr_q  <= 1'b0;
         rd_q  <= 1'b0;
         cap_q <= rd_q;
         if (cap_q) tx_sh <= reg_rdata;
         if (wr_q)  ptr   <= ptr + 1'b1;

         if (start_evt) begin
            phase   <= PH_DEV;
            bit_cnt <= '0;
            oe      <= 1'b0;
            w_cnt   <= '0;
         end else if (stop_evt) begin
            phase   <= PH_IDLE;
            oe      <= 1'b0;
            w_cnt   <= '0;
         end else if (scl_rise) begin
            case (phase)
               PH_DEV, PH_RX: begin
                  if (bit_cnt != 4'd8) begin
                     shreg   <= {shreg[6:0], sda_in};
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
               PH_TXACK: mack <= ~sda_in;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (phase)
               PH_DEV: begin
                  if (bit_cnt == 4'd8) begin
                     bit_cnt <= '0;
                     if (shreg[7:1] == DEV_ADDR) begin
                        phase   <= PH_ACK;
                        oe      <= 1'b1;
                        reading <= shreg[0];
                        a_cnt   <= '0;
                        w_cnt   <= '0;
                        tx_cnt  <= '0;
                        if (shreg[0]) rd_q <= 1'b1;
                     end else begin
                        phase <= PH_IDLE;
                        oe    <= 1'b0;
                     end
                  end
               end
               PH_RX: begin
                  if (bit_cnt == 4'd8) begin
                     bit_cnt <= '0;
                     phase   <= PH_ACK;
                     oe      <= 1'b1;
                     if (a_cnt != ACW'(ABYTES)) begin
                        pacc  <= {pacc[AW-9:0], shreg};
                        a_cnt <= a_cnt + 1'b1;
                        if (a_cnt == ACW'(ABYTES - 1)) ptr <= {pacc[AW-9:0], shreg};
                     end else begin
                        wbuf <= {wbuf[DW-9:0], shreg};
                        if (w_cnt == DCW'(DBYTES - 1)) begin
                           w_cnt   <= '0;
                           wr_q    <= 1'b1;
                           wdata_q <= {wbuf[DW-9:0], shreg};
                        end else begin
                           w_cnt <= w_cnt + 1'b1;
                        end
                     end
                  end
               end
               PH_ACK: begin
                  if (reading) begin
                     phase   <= PH_TX;
                     oe      <= ~tx_sh[DW-1];
                     tx_sh   <= tx_sh << 1;
                     bit_cnt <= 4'd1;
                  end else begin
                     phase   <= PH_RX;
                     oe      <= 1'b0;
                     bit_cnt <= '0;
                  end
               end
               PH_TX: begin
                  if (bit_cnt == 4'd8) begin
                     oe      <= 1'b0;
                     phase   <= PH_TXACK;
                     bit_cnt <= '0;
                     if (tx_cnt == DCW'(DBYTES - 1)) begin
                        tx_cnt <= '0;
                        ptr    <= ptr + 1'b1;
                        rd_q   <= 1'b1;
                     end else begin
                        tx_cnt <= tx_cnt + 1'b1;
                     end
                  end else begin
                     oe      <= ~tx_sh[DW-1];
                     tx_sh   <= tx_sh << 1;
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
               PH_TXACK: begin
                  if (mack) begin
                     phase   <= PH_TX;
                     oe      <= ~tx_sh[DW-1];
                     tx_sh   <= tx_sh << 1;
                     bit_cnt <= 4'd1;
                  end else begin
                     phase <= PH_IDLE;
                     oe    <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = oe;
   assign reg_wr_en = wr_q;
   assign reg_rd_en = rd_q;
   assign reg_addr  = ptr;
   assign reg_wdata = wdata_q;
   assign idle_o    = (phase == PH_IDLE);
endmodule

// File: rtl/i2c_word_regslave.sv
module i2c_word_regslave #(
   parameter logic [6:0] DEV_ADDR    = 7'h2A,
   parameter int         AW          = 16,
   parameter int         DW          = 16,
   parameter int         SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic          reg_wr_en,
   output logic          reg_rd_en,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   input  logic [DW-1:0] reg_rdata
);
   localparam int NLINES = 2;

   if (AW < 16 || (AW % 8) != 0) begin : g_bad_aw
      $error("AW must be a multiple of 8 and at least 16");
   end
   if (DW < 16 || (DW % 8) != 0) begin : g_bad_dw
      $error("DW must be a multiple of 8 and at least 16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] raw_lines, synced;
   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_evt, stop_evt;
   logic proto_idle;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_sync
      i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_lines[g]),
         .dout (synced[g])
      );
   end

   assign scl_s = synced[0];
   assign sda_s = synced[1];

   i2cw_bus_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_s),
      .sda      (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt)
   );

   i2cw_proto #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_proto (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .sda_in   (sda_s),
      .start_evt(start_evt),
      .stop_evt (stop_evt),
      .sda_oe   (sda_oe),
      .reg_wr_en(reg_wr_en),
      .reg_rd_en(reg_rd_en),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .idle_o   (proto_idle)
   );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_s,
   input logic          start_evt,
   input logic          sda_oe,
   input logic          wr_en,
   input logic          rd_en,
   input logic [AW-1:0] addr,
   input logic          idle
);
   assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (addr == AW'($past(addr) + 1'b1)));

   assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));

   assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !sda_oe);

   assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_evt) |-> !sda_oe);
endmodule

bind i2c_word_regslave i2cw_checker #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .start_evt(start_evt),
   .sda_oe   (sda_oe),
   .wr_en    (reg_wr_en),
   .rd_en    (reg_rd_en),
   .addr     (reg_addr),
   .idle     (proto_idle)
);

// File: tb/i2c_word_regslave_bench.sv
`timescale 1ns/1ps
module i2c_word_regslave_bench;
   localparam logic [6:0] DEV = 7'h2A;
   localparam int Q = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        m_scl;
   logic        m_sda_low;
   logic        dut_oe, dut_wr, dut_rd;
   logic [15:0] dut_addr, dut_wdata;
   logic [15:0] rf_rdata = 16'h0;
   logic        sda_line;

   int n_run = 0;
   int n_fail = 0;
   int hold_viol = 0;

   logic [15:0] rf_mem  [int];
   logic [15:0] ref_mem [int];
   logic [31:0] exp_wq[$];
   logic [15:0] tx_words[$];
   logic [15:0] exp_ptr = 16'h0;
   string       cur_req = "R5";

   always #5 clk = ~clk;

   assign sda_line = ~(m_sda_low | dut_oe);

   i2c_word_regslave #(.DEV_ADDR(DEV)) u_i2c_word_regslave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_line),
      .sda_oe   (dut_oe),
      .reg_wr_en(dut_wr),
      .reg_rd_en(dut_rd),
      .reg_addr (dut_addr),
      .reg_wdata(dut_wdata),
      .reg_rdata(rf_rdata)
   );

   // register file model with one-cycle read latency
   always @(posedge clk) begin
      if (dut_wr) rf_mem[int'(dut_addr)] = dut_wdata;
      if (dut_rd) rf_rdata <= rf_mem.exists(int'(dut_addr)) ? rf_mem[int'(dut_addr)] : 16'h0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rget(input logic [15:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
   endfunction

   // per-clock comparison of write strobes and line discipline
   logic prev_scl = 1'b1, prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (dut_wr) begin
            if (exp_wq.size() == 0) begin
               chk(1'b0, cur_req, "unexpected write strobe", {dut_addr, dut_wdata}, 32'h0);
            end else begin
               logic [31:0] e;
               e = exp_wq.pop_front();
               chk({dut_addr, dut_wdata} == e, "R5", "write addr/data", {dut_addr, dut_wdata}, e);
            end
         end
         if (m_scl && prev_scl && (dut_oe != prev_oe)) hold_viol++;
      end
      prev_scl = m_scl;
      prev_oe  = dut_oe;
   end

   task automatic qwait();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0; qwait();
      m_scl = 1'b1;     qwait();
      m_sda_low = 1'b1; qwait();
      m_scl = 1'b0;     qwait();
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; qwait();
      m_scl = 1'b1;     qwait();
      m_sda_low = 1'b0; qwait();
      qwait();
   endtask

   task automatic wr_bit(input bit b);
      m_sda_low = ~b; qwait();
      m_scl = 1'b1;   qwait(); qwait();
      m_scl = 1'b0;   qwait();
   endtask

   task automatic rd_bit(output bit b);
      m_sda_low = 1'b0; qwait();
      m_scl = 1'b1;     qwait();
      b = sda_line;     qwait();
      m_scl = 1'b0;     qwait();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit acked);
      bit s;
      for (int i = 7; i >= 0; i--) wr_bit(v[i]);
      rd_bit(s);
      acked = ~s;
   endtask

   task automatic recv_byte(output logic [7:0] v, input bit give_ack);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         rd_bit(s);
         v[i] = s;
      end
      wr_bit(~give_ack);
   endtask

   task automatic do_write(input logic [15:0] addr, input string req);
      bit a;
      int nacks = 0;
      logic [15:0] p;
      bus_start();
      send_byte({DEV, 1'b0}, a); nacks += int'(!a);
      send_byte(addr[15:8], a);  nacks += int'(!a);
      send_byte(addr[7:0], a);   nacks += int'(!a);
      p = addr;
      foreach (tx_words[i]) begin
         exp_wq.push_back({p, tx_words[i]});
         ref_mem[int'(p)] = tx_words[i];
         send_byte(tx_words[i][15:8], a); nacks += int'(!a);
         send_byte(tx_words[i][7:0], a);  nacks += int'(!a);
         p = p + 16'h1;
      end
      bus_stop();
      exp_ptr = p;
      chk(nacks == 0, req, "write bytes acknowledged (R2/R4 path)", nacks, 0);
   endtask

   task automatic do_read(input logic [15:0] addr, input int n, input bit set_ptr, input string req);
      bit a;
      logic [7:0] hi, lo;
      logic [15:0] p;
      if (set_ptr) begin
         bus_start();
         send_byte({DEV, 1'b0}, a); chk(a, "R4", "pointer phase ack", a, 1);
         send_byte(addr[15:8], a);
         send_byte(addr[7:0], a);
         p = addr;
      end else begin
         p = exp_ptr;
      end
      bus_start();
      send_byte({DEV, 1'b1}, a);
      chk(a, "R2", "read address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(hi, 1'b1);
         recv_byte(lo, (i != n - 1));
         chk({hi, lo} == rget(p), req, "read word", {hi, lo}, rget(p));
         p = p + 16'h1;
      end
      chk(!dut_oe && sda_line, "R10", "line released after NACK", dut_oe, 0);
      bus_stop();
      exp_ptr = p;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      bit a;
      rst_n = 1'b0; m_scl = 1'b1; m_sda_low = 1'b0;
      repeat (5) @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (3) @(posedge clk); #1;

      // R1 reset state
      chk(dut_oe == 1'b0, "R1", "sda_oe after reset", dut_oe, 0);
      chk(!dut_wr && !dut_rd, "R1", "strobes after reset", {dut_wr, dut_rd}, 0);
      chk(dut_addr == 16'h0, "R1", "pointer after reset", dut_addr, 0);

      // R5 single write
      tx_words.delete(); tx_words.push_back(16'hBEEF);
      do_write(16'h1234, "R5");

      // R6 burst write crossing a byte boundary
      tx_words.delete();
      for (int i = 0; i < 4; i++) tx_words.push_back(16'hA500 + 16'(i * 7));
      do_write(16'h00FE, "R6");

      // R8 random read via repeated start, R12 read port
      do_read(16'h1234, 1, 1'b1, "R8");
      // R9 burst read ended by NACK
      do_read(16'h00FE, 3, 1'b1, "R9");
      // R11 continuing read picks up at n+3 -> 0x0101
      chk(exp_ptr == 16'h0101, "R11", "bench pointer", exp_ptr, 16'h0101);
      do_read(16'h0, 1, 1'b0, "R11");

      // R3 foreign device address
      cur_req = "R3";
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b0}, a);
      chk(!a, "R3", "foreign address not acknowledged", a, 0);
      for (int i = 0; i < 4; i++) begin
         send_byte(8'h12 + 8'(i * 33), a);
         chk(!a, "R3", "byte ignored after mismatch", a, 0);
      end
      bus_stop();
      do_read(16'h1234, 1, 1'b1, "R3");

      // R7 lone high byte then STOP
      cur_req = "R7";
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h12, a);
      send_byte(8'h34, a);
      send_byte(8'h11, a);
      chk(a, "R5", "lone data byte acknowledged", a, 1);
      bus_stop();
      do_read(16'h1234, 1, 1'b1, "R7");
      cur_req = "R5";

      // R6 pointer wrap at the top of the space
      tx_words.delete(); tx_words.push_back(16'h5A5A); tx_words.push_back(16'hC3C3);
      do_write(16'hFFFF, "R6");
      chk(exp_ptr == 16'h0001, "R6", "wrapped pointer", exp_ptr, 16'h0001);
      do_read(16'h0, 2, 1'b0, "R11");
      do_read(16'hFFFF, 2, 1'b1, "R6");

      // mixed patterns: bursts written then read back, then continued
      for (int k = 0; k < 3; k++) begin
         tx_words.delete();
         for (int j = 0; j < k + 2; j++) tx_words.push_back(16'((k + 1) * 16'h1357 ^ (j * 16'h0F0F)));
         do_write(16'h0400 + 16'(k * 16'h0111), "R5");
         do_read(16'h0400 + 16'(k * 16'h0111), k + 1, 1'b1, "R9");
         do_read(16'h0, 1, 1'b0, "R11");
      end

      repeat (20) @(posedge clk); #1;
      chk(exp_wq.size() == 0, "R5", "expected writes all seen", exp_wq.size(), 0);
      chk(hold_viol == 0, "R8", "sda_oe steady while SCL high", hold_viol, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule